// File: doc/BRIEF.md
# Clock-Stop Serial Master with Programmable Bit-Clock Divider

This block is a serial master for one word per transfer. A start strobe latches a transmit word, a divide value and a word-length code. The block then lowers an active-low select line and shifts the word out on `mosi`, most significant bit first. It collects a word of the same length from `miso`. The serial clock is not free-running. It rests high whenever no word is in progress, and it toggles only while select is low.

The block runs from `clk`, which is twice the sample rate: one sample period is two `clk` cycles. This lets every phase length be a whole number of cycles, even when the divide value is zero. For a divide value g, one bit period lasts 1+g sample periods. For even nonzero g, the high phase is one sample period longer than the low phase. Otherwise the two phases are equal.

The controller is a state machine with six states:
- `ST_IDLE`: rest with select high.
- `ST_LEAD`: select low, clock still high.
- `ST_CLK_LO`: clock low phase.
- `ST_CLK_HI`: clock high phase.
- `ST_DONE`: select released and done pulse.
- `ST_REST`: enforced idle sample period.

The state transitions are:
- IDLE to LEAD on start.
- LEAD to CLK_LO when the lead count expires.
- CLK_LO to CLK_HI when the low count expires.
- CLK_HI to CLK_LO when the high count expires and bits remain.
- CLK_HI to DONE after the last bit.
- DONE to REST unconditionally.
- REST to LEAD on start, or REST to IDLE otherwise.

Top module: `cs_spi_master`

## Requirements
- R1: During reset `sclk`=1, `ss_n`=1, `mosi_oe`=0, `done`=0 and `rx_word`=0.
- R2: `sclk` stays high whenever `ss_n` is high. After a start, `ss_n` falls with `sclk` still high, and this lead lasts the low-phase length before the first falling edge.
- R3: One serial-clock period (low plus high) lasts 2*(1+g) `clk` cycles, where g is the divide value latched at start.
- R4: For even nonzero g, each high phase lasts g+2 `clk` cycles and each low phase lasts g cycles.
- R5: For g zero or odd, both the high and the low phase last g+1 `clk` cycles.
- R6: `mosi` is driven with `mosi_oe`=1 while `ss_n` is low. The first bit is valid when `ss_n` falls, and later bits change only with falling edges of `sclk`. The value seen at the rising edges is the transmit word, from bit n-1 down to bit 0.
- R7: `miso` is sampled at each rising edge of `sclk`. At the end of the word, `rx_word` holds the n sampled bits right-justified, first sample in bit n-1, and the bits above n-1 are zero.
- R8: `len_sel` chooses n: 2'b00 gives 8, 2'b01 gives 16, and 2'b10 or 2'b11 gives 32. A word has exactly n rising edges.
- R9: After the last rising edge, one high phase elapses. Then, in the same cycle, `ss_n` rises, `mosi_oe` falls and `done` pulses for exactly one cycle with `rx_word` valid.
- R10: A start while a word is in progress, or in the cycle of `done`, is ignored. The word in flight is unchanged, and no further word follows it.
- R11: A change of `div_val` during a word has no effect on that word's phases.
- R12: With start held high continuously, `ss_n` stays high for exactly 2 `clk` cycles (one sample period) between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Twice-sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a word when not busy |
| tx_word | input | 32 | Word to send, right-justified |
| div_val | input | DIV_W | Divide value g |
| len_sel | input | 2 | Word-length code |
| miso | input | 1 | Serial input from slave |
| sclk | output | 1 | Serial clock, rests high |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial output data |
| mosi_oe | output | 1 | Output enable for `mosi` |
| rx_word | output | 32 | Received word, right-justified |
| done | output | 1 | One-cycle end-of-word pulse |

## Verification
The hardest situations to reach are a start strobe that lands mid-word, together with a divide change, and the shortest possible gap between words. The bench reaches the first by raising `start` at a chosen cycle inside a word, while presenting an inverted transmit word and a new divide value. It then measures every phase of that word against the old divide value. It confirms that the inverted data never appears and that the select line stays high afterwards. For the gap, `start` is held high across a word boundary, and the cycles of high select between the two words are counted.

// File: rtl/cs_spi_pkg.sv
package cs_spi_pkg;

    localparam int WORD_MAX = 32;
    localparam int BITIDX_W = $clog2(WORD_MAX);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_DONE,
        ST_REST
    } spi_state_t;

    // Index of the first bit sent: n-1 for the selected word length.
    function automatic logic [BITIDX_W-1:0] top_index(input logic [1:0] sel);
        logic [BITIDX_W-1:0] idx;
        unique case (sel)
            2'b00:   idx = BITIDX_W'(7);
            2'b01:   idx = BITIDX_W'(15);
            default: idx = BITIDX_W'(WORD_MAX - 1);
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/cs_spi_phase_calc.sv
// Converts the divide value into high/low phase lengths counted in clk
// cycles (clk runs at twice the sample rate).
module cs_spi_phase_calc #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div,
    output logic [DIV_W:0]   hi_len,
    output logic [DIV_W:0]   lo_len
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] div_ext;

    always_comb begin
        div_ext = {1'b0, div};
        if (div == '0 || div[0]) begin
            hi_len = div_ext + CNT_W'(1);
            lo_len = div_ext + CNT_W'(1);
        end else begin
            hi_len = div_ext + CNT_W'(2);
            lo_len = div_ext;
        end
    end

endmodule

// File: rtl/cs_spi_shifter.sv
// Transmit and receive shift registers, MSB first.
module cs_spi_shifter
    import cs_spi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WORD_MAX-1:0] tx_word,
    input  logic [1:0]          len_sel,
    input  logic                shift_out,
    input  logic                sample_in,
    input  logic                miso,
    output logic                mosi_bit,
    output logic [WORD_MAX-1:0] rx_data
);
    logic [WORD_MAX-1:0] tx_sh;
    logic [BITIDX_W-1:0] align;

    // Left-align the word so that bit n-1 sits at the top of the register.
    always_comb begin
        align = BITIDX_W'(WORD_MAX - 1) - top_index(len_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_data <= '0;
        end else if (load) begin
            tx_sh   <= tx_word << align;
            rx_data <= '0;
        end else begin
            if (shift_out) tx_sh   <= {tx_sh[WORD_MAX-2:0], 1'b0};
            if (sample_in) rx_data <= {rx_data[WORD_MAX-2:0], miso};
        end
    end

    assign mosi_bit = tx_sh[WORD_MAX-1];

endmodule

// File: rtl/cs_spi_master.sv
module cs_spi_master
    import cs_spi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WORD_MAX-1:0] tx_word,
    input  logic [DIV_W-1:0]    div_val,
    input  logic [1:0]          len_sel,
    input  logic                miso,
    output logic                sclk,
    output logic                ss_n,
    output logic                mosi,
    output logic                mosi_oe,
    output logic [WORD_MAX-1:0] rx_word,
    output logic                done
);
    localparam int CNT_W = DIV_W + 1;

    spi_state_t          state, nxt;
    logic [CNT_W-1:0]    hi_calc, lo_calc;
    logic [CNT_W-1:0]    hi_q, lo_q, cnt;
    logic [BITIDX_W-1:0] bits_left;
    logic [WORD_MAX-1:0] rx_data;
    logic                mosi_bit;
    logic                accept, cnt_end, last_bit;
    logic                to_hi, shift_out, word_end;

    cs_spi_phase_calc #(.DIV_W(DIV_W)) u_phase (
        .div    (div_val),
        .hi_len (hi_calc),
        .lo_len (lo_calc)
    );

    cs_spi_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tx_word   (tx_word),
        .len_sel   (len_sel),
        .shift_out (shift_out),
        .sample_in (to_hi),
        .miso      (miso),
        .mosi_bit  (mosi_bit),
        .rx_data   (rx_data)
    );

    always_comb begin
        cnt_end   = (cnt == '0);
        last_bit  = (bits_left == '0);
        accept    = start && (state == ST_IDLE || state == ST_REST);
        to_hi     = (state == ST_CLK_LO) && cnt_end;
        shift_out = (state == ST_CLK_HI) && cnt_end && !last_bit;
        word_end  = (state == ST_CLK_HI) && cnt_end && last_bit;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_LEAD;
            ST_LEAD:   if (cnt_end) nxt = ST_CLK_LO;
            ST_CLK_LO: if (cnt_end) nxt = ST_CLK_HI;
            ST_CLK_HI: if (cnt_end) nxt = last_bit ? ST_DONE : ST_CLK_LO;
            ST_DONE:   nxt = ST_REST;
            ST_REST:   nxt = start ? ST_LEAD : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Phase counter, latched divider and bit counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            lo_q      <= '0;
            cnt       <= '0;
            bits_left <= '0;
            rx_word   <= '0;
        end else begin
            if (accept) begin
                hi_q      <= hi_calc;
                lo_q      <= lo_calc;
                cnt       <= lo_calc - CNT_W'(1);
                bits_left <= top_index(len_sel);
            end else if (state == ST_LEAD && cnt_end) begin
                cnt <= lo_q - CNT_W'(1);
            end else if (to_hi) begin
                cnt <= hi_q - CNT_W'(1);
            end else if (shift_out) begin
                cnt       <= lo_q - CNT_W'(1);
                bits_left <= bits_left - BITIDX_W'(1);
            end else if (!cnt_end) begin
                cnt <= cnt - CNT_W'(1);
            end
            if (word_end) rx_word <= rx_data;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        sclk    = (state != ST_CLK_LO);
        ss_n    = !(state == ST_LEAD || state == ST_CLK_LO || state == ST_CLK_HI);
        mosi_oe = !ss_n;
        mosi    = mosi_oe && mosi_bit;
        done    = (state == ST_DONE);
    end

    // ---------------- assertions ----------------
    assert_clk_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> !ss_n)
        else $error("sclk moved while select high");

    assert_release_on_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> (sclk && done && !mosi_oe))
        else $error("select released without high clock and done");

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one cycle");

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && start) |=> ($stable(hi_q) && $stable(lo_q) && $stable(bits_left) || shift_out || $past(shift_out)))
        else $error("start accepted while busy");

    assert_min_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |=> ss_n)
        else $error("select reasserted without idle gap");

    assert_lead_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> sclk)
        else $error("select fell with clock low");

endmodule

// File: tb/cs_spi_master_bench.sv
module cs_spi_master_bench;

    logic        clk = 1'b0;
    logic        rst_n, start, miso;
    logic [31:0] tx_word;
    logic [7:0]  div_val;
    logic [1:0]  len_sel;
    logic        sclk, ss_n, mosi, mosi_oe, done;
    logic [31:0] rx_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cs_spi_master #(.DIV_W(8)) u_cs_spi_master (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .div_val(div_val), .len_sel(len_sel), .miso(miso),
        .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .mosi_oe(mosi_oe),
        .rx_word(rx_word), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    function automatic int nbits(input logic [1:0] s);
        return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    endfunction

    function automatic int hi_exp(input int g);
        return (g == 0 || (g % 2) == 1) ? g + 1 : g + 2;
    endfunction

    function automatic int lo_exp(input int g);
        return (g == 0 || (g % 2) == 1) ? g + 1 : g;
    endfunction

    // Runs one word, models the slave, measures every phase.
    task automatic run_word(input logic [31:0] tx, input logic [31:0] miso_w,
                            input int g, input logic [1:0] ls,
                            input int poke_at, input int g2);
        int n = nbits(ls);
        int hi = hi_exp(g);
        int lo = lo_exp(g);
        logic [31:0] mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
        logic [31:0] cap = '0;
        string ptag = (g != 0 && (g % 2) == 0) ? "R4" : "R5";
        int run = 0, rises = 0, lead_len = -1, hi_bad = 0, lo_bad = 0;
        int first_lo = -1, first_hi = -1, oe_bad = 0;
        bit lead_phase = 0, prev_s = 1, prev_ss = 1, ended = 0;
        @(negedge clk);
        tx_word = tx; div_val = 8'(g); len_sel = ls; start = 1'b1;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (poke_at > 0 && cyc == poke_at) begin
                start = 1'b1; tx_word = ~tx; div_val = 8'(g2);
            end else if (poke_at > 0 && cyc == poke_at + 1) begin
                start = 1'b0;
            end
            if (!ss_n && prev_ss) begin
                run = 1; lead_phase = 1;
                miso = miso_w[n-1];
                check(sclk == 1'b1, "R2", "clock high at select fall", int'(sclk), 1);
                check(mosi == tx[n-1], "R6", "first bit at select fall", int'(mosi), int'(tx[n-1]));
            end else if (!ss_n) begin
                if (sclk == prev_s) run++;
                else begin
                    if (prev_s) begin
                        if (lead_phase) begin lead_len = run; lead_phase = 0; end
                        else begin
                            if (run != hi) hi_bad++;
                            if (first_hi < 0) first_hi = run;
                        end
                    end else begin
                        if (run != lo) lo_bad++;
                        if (first_lo < 0) first_lo = run;
                    end
                    if (sclk) begin
                        rises++;
                        cap = {cap[30:0], mosi};
                        if (!mosi_oe) oe_bad++;
                    end else if (rises > 0 && rises < n) begin
                        miso = miso_w[n-1-rises];
                    end
                    run = 1;
                end
            end else if (!prev_ss) begin
                if (!prev_s) lo_bad++;
                else begin
                    if (run != hi) hi_bad++;
                    if (first_hi < 0) first_hi = run;
                end
                check(done == 1'b1, "R9", "done with select rise", int'(done), 1);
                check(mosi_oe == 1'b0, "R9", "output released", int'(mosi_oe), 0);
                check(rx_word == (miso_w & mask), "R7", "received word", int'(rx_word), int'(miso_w & mask));
                ended = 1;
                break;
            end
            prev_s = sclk; prev_ss = ss_n;
        end
        check(ended, "R9", "word completed", int'(ended), 1);
        check(lead_len == lo, "R2", "lead length", lead_len, lo);
        check(hi_bad == 0, ptag, "bad high phases", hi_bad, 0);
        check(lo_bad == 0, ptag, "bad low phases", lo_bad, 0);
        check(first_lo + first_hi == 2 * (g + 1), "R3", "period", first_lo + first_hi, 2 * (g + 1));
        check(rises == n, "R8", "rising edges", rises, n);
        check(cap == (tx & mask), "R6", "sent bits", int'(cap), int'(tx & mask));
        check(oe_bad == 0, "R6", "oe low at a rising edge", oe_bad, 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done one cycle", int'(done), 0);
    endtask

    task automatic idle_check(input string tag, input int cycles);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!sclk || !ss_n) bad++;
        end
        check(bad == 0, tag, "idle with clock and select high", bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; tx_word = '0; div_val = '0;
        len_sel = 2'b00; miso = 1'b0;
        repeat (3) @(negedge clk);
        check(sclk == 1'b1 && ss_n == 1'b1, "R1", "clock/select in reset", int'({sclk, ss_n}), 3);
        check(mosi_oe == 1'b0 && done == 1'b0, "R1", "oe/done in reset", int'({mosi_oe, done}), 0);
        check(rx_word == 32'h0, "R1", "rx_word in reset", int'(rx_word), 0);
        rst_n = 1'b1;
        idle_check("R2", 4);
    endtask

    task automatic t_even();
        run_word(32'h0000_00A5, 32'h0000_003C, 2, 2'b00, 0, 0);
        run_word(32'h0000_00C3, 32'hFFFF_FF81, 6, 2'b00, 0, 0);
        idle_check("R2", 6);
    endtask

    task automatic t_odd();
        run_word(32'h1234_9E4D, 32'hABCD_71B2, 3, 2'b01, 0, 0);
    endtask

    task automatic t_zero();
        run_word(32'hDEAD_BEEF, 32'h8000_0001, 0, 2'b10, 0, 0);
        run_word(32'h5A5A_0F0F, 32'h0F0F_A5A5, 0, 2'b11, 0, 0);
    endtask

    task automatic t_busy();
        // R10 and R11: start plus new divider and data mid-word
        run_word(32'h0000_0096, 32'h0000_0069, 1, 2'b00, 5, 4);
        idle_check("R10", 12);
        // R11: the next word uses the new divider
        run_word(32'h0000_0011, 32'h0000_0022, 4, 2'b00, 0, 0);
    endtask

    task automatic t_b2b();
        int gap = 0;
        bit seen = 0;
        @(negedge clk);
        tx_word = 32'h0000_00F0; div_val = 8'd0; len_sel = 2'b00; start = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) seen = 1;
            if (seen && ss_n) gap++;
            if (seen && !ss_n) break;
        end
        start = 1'b0;
        check(gap == 2, "R12", "select-high gap", gap, 2);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        idle_check("R12", 4);
    endtask

    initial begin
        t_reset();
        t_even();
        t_odd();
        t_zero();
        t_busy();
        t_b2b();
        finish_sim();
    end

endmodule